// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block sets the number of bus-clock cycles that each memory access takes, then runs that access toward the CPU core with a busy/done handshake. For every request the core supplies a decoded area class: special-function registers, internal ROM/RAM, or the external area together with a 2-bit chip-select index. It also supplies a flag that marks the external bus as separate or multiplexed. A fixed priority table turns the area class, the bus mode, a global wait bit and one speed bit per chip select into a length of one, two or three cycles.

Configuration lives in three byte-wide registers on a simple write port. The first holds the bus-clock float control, which drives the bus-clock output enable. The second holds the global wait bit. The third holds one speed bit per chip select. Each of these three takes a write only while a lock-release bit in a separate protect register is set. The protect register itself is always writable. The length of an access is fixed when the request is accepted, so a configuration write made during an access changes only later accesses.

Top module: `bus_wait_ctrl`

## Requirements
- R1: A request with area code 0 (special-function registers) lasts exactly 2 cycles, whatever the configuration holds.
- R2: A request with area code 1 (internal ROM/RAM) lasts 1 cycle when the global wait bit is 0 and 2 cycles when it is 1. The chip-select speed bits have no effect on it.
- R3: A request with area code 2 (external) and mux_bus=0, made with the global wait bit at 0, lasts 1 cycle when the speed bit of its chip select is 1 and 2 cycles when that bit is 0. Chip select i uses bit 4+i of the chip-select register.
- R4: With the global wait bit at 1, an external access on the separate bus lasts 2 cycles and one on the multiplexed bus lasts 3 cycles, whatever the speed bits hold.
- R5: An external access with mux_bus=1 always lasts 3 cycles, even when its speed bit is 1.
- R6: After reset busy=0, done=0 and bclk_oe=1. The global wait bit, all speed bits and the protect bit reset to 0.
- R7: bclk_oe is the inverse of bit 7 of the register at address 0, and it changes only after a write to that register.
- R8: Writes to address 0 (float, bit 7), address 1 (global wait, bit 7) and address 2 (speed bits 7..4) take effect only while protect bit 1 is 1. Otherwise they are ignored.
- R9: A request is sampled at a clock edge while the controller is idle. For an access of L cycles, busy is high in the first L-1 cycles after that edge and done is high for exactly one cycle, the L-th. busy and done are never high together.
- R10: The cycle after done is always idle, with busy=0 and done=0. A request held high is accepted at the end of that cycle.
- R11: Writes to address 3 (protect, bit 1) are never gated, and the protect bit keeps its value until it is written again.
- R12: Area code 3 is reserved and is handled like area code 0 (2 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request strobe |
| area | input | 2 | Area class: 0 SFR, 1 internal, 2 external, 3 reserved |
| cs_idx | input | 2 | Chip-select index for external accesses |
| mux_bus | input | 1 | 1 = multiplexed external bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address (0..3) |
| cfg_wdata | input | 8 | Configuration write data |
| busy | output | 1 | Access in progress, before its last cycle |
| done | output | 1 | Last cycle of the access |
| bclk_oe | output | 1 | Bus-clock output enable (0 = floated) |

## Verification
On every cycle the assertions check the handshake shape: busy and done are never high together, done lasts one cycle and is followed by an idle cycle, special-function accesses run for two cycles, and multiplexed external accesses run for three. They also check that bclk_oe holds its value when no write is made and when a write is made while the protect bit is clear. Only the bench's scenarios can show the full table. That means the separate-bus speed bits per chip select, the effect of the global wait bit on internal and external areas, whether ignored writes to the wait and speed registers really leave the lengths unchanged, the reset defaults, and the spacing of back-to-back requests.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    AREA_SFR = 2'd0,
    AREA_INT = 2'd1,
    AREA_EXT = 2'd2,
    AREA_RSV = 2'd3
  } area_e;

  localparam int CFG_ADDR_W = 2;

  localparam logic [CFG_ADDR_W-1:0] ADDR_CLKCTL = 2'd0;
  localparam logic [CFG_ADDR_W-1:0] ADDR_WAIT   = 2'd1;
  localparam logic [CFG_ADDR_W-1:0] ADDR_CSSPD  = 2'd2;
  localparam logic [CFG_ADDR_W-1:0] ADDR_LOCK   = 2'd3;

  localparam int CTL_BIT    = 7;
  localparam int LOCK_BIT   = 1;
  localparam int CS_SPD_LSB = 4;

  localparam int LEN_W = 2;
  localparam logic [LEN_W-1:0] LEN_FAST = 2'd1;
  localparam logic [LEN_W-1:0] LEN_WAIT = 2'd2;
  localparam logic [LEN_W-1:0] LEN_MUX  = 2'd3;

endpackage

// File: rtl/bwc_cfg_regs.sv
module bwc_cfg_regs
  import bwc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NCS    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic                  float_q,
  output logic                  wait_q,
  output logic [NCS-1:0]        cs_fast_q,
  output logic                  lock_off_q
);

  localparam int CS_MSB = CS_SPD_LSB + NCS - 1;

  logic           float_d;
  logic           wait_d;
  logic [NCS-1:0] cs_fast_d;
  logic           lock_off_d;
  logic           wr_ok;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  assign wr_ok = cfg_we & lock_off_q;

  always_comb begin
    float_d    = float_q;
    wait_d     = wait_q;
    cs_fast_d  = cs_fast_q;
    lock_off_d = lock_off_q;
    if (cfg_we && cfg_addr == ADDR_LOCK) begin
      lock_off_d = cfg_wdata[LOCK_BIT];
    end
    if (wr_ok && cfg_addr == ADDR_CLKCTL) begin
      float_d = cfg_wdata[CTL_BIT];
    end
    if (wr_ok && cfg_addr == ADDR_WAIT) begin
      wait_d = cfg_wdata[CTL_BIT];
    end
    if (wr_ok && cfg_addr == ADDR_CSSPD) begin
      cs_fast_d = cfg_wdata[CS_MSB:CS_SPD_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      float_q    <= 1'b0;
      wait_q     <= 1'b0;
      lock_off_q <= 1'b0;
    end else begin
      float_q    <= float_d;
      wait_q     <= wait_d;
      lock_off_q <= lock_off_d;
    end
  end

  generate
    for (genvar g = 0; g < NCS; g++) begin : g_cs
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_fast_q[g] <= 1'b0;
        else        cs_fast_q[g] <= cs_fast_d[g];
      end
    end
  endgenerate

endmodule

// File: rtl/bwc_len_lut.sv
module bwc_len_lut
  import bwc_pkg::*;
#(
  parameter int NCS = 4,
  localparam int CS_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [1:0]       area,
  input  logic [CS_W-1:0]  cs_idx,
  input  logic             mux_bus,
  input  logic             wait_en,
  input  logic [NCS-1:0]   cs_fast,
  output logic [LEN_W-1:0] len
);

  logic sel_fast;
  assign sel_fast = cs_fast[cs_idx];

  // Priority: SFR/reserved > multiplexed > global wait > per-CS speed
  always_comb begin
    unique case (area)
      AREA_INT: len = wait_en ? LEN_WAIT : LEN_FAST;
      AREA_EXT: begin
        if (mux_bus)       len = LEN_MUX;
        else if (wait_en)  len = LEN_WAIT;
        else if (sel_fast) len = LEN_FAST;
        else               len = LEN_WAIT;
      end
      default:  len = LEN_WAIT;
    endcase
  end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
  import bwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LEN_W-1:0] len_in,
  output logic             busy,
  output logic             done
);

  logic             active_q, active_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             last;
  logic             cnt_en;

  assign last   = (rem_q == LEN_W'(1));
  assign cnt_en = active_q | req;

  always_comb begin
    active_d = active_q;
    rem_d    = rem_q;
    if (!active_q) begin
      if (req) begin
        active_d = 1'b1;
        rem_d    = len_in;
      end
    end else if (last) begin
      active_d = 1'b0;
    end else begin
      rem_d = rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (cnt_en) begin
      active_q <= active_d;
      rem_q    <= rem_d;
    end
  end

  assign busy = active_q & ~last;
  assign done = active_q &  last;

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NCS    = 4,
  localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [1:0]            area,
  input  logic [CS_W-1:0]       cs_idx,
  input  logic                  mux_bus,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic                  busy,
  output logic                  done,
  output logic                  bclk_oe
);

  logic             float_q;
  logic             wait_q;
  logic [NCS-1:0]   cs_fast_q;
  logic             prot_on;
  logic [LEN_W-1:0] len;

  bwc_cfg_regs #(.DATA_W(DATA_W), .NCS(NCS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .float_q    (float_q),
    .wait_q     (wait_q),
    .cs_fast_q  (cs_fast_q),
    .lock_off_q (prot_on)
  );

  bwc_len_lut #(.NCS(NCS)) u_lut (
    .area    (area),
    .cs_idx  (cs_idx),
    .mux_bus (mux_bus),
    .wait_en (wait_q),
    .cs_fast (cs_fast_q),
    .len     (len)
  );

  bwc_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .len_in (len),
    .busy   (busy),
    .done   (done)
  );

  assign bclk_oe = ~float_q;

endmodule

// File: rtl/bus_wait_ctrl_chk.sv
module bus_wait_ctrl_chk
  import bwc_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req,
  input logic [1:0]            area,
  input logic                  mux_bus,
  input logic                  cfg_we,
  input logic [CFG_ADDR_W-1:0] cfg_addr,
  input logic                  busy,
  input logic                  done,
  input logic                  bclk_oe,
  input logic                  prot_on
);

  logic accept;
  assign accept = req & ~busy & ~done;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10

  AST_SFR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && area == AREA_SFR) |=> busy ##1 done); // R1

  AST_MUX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && area == AREA_EXT && mux_bus) |=> busy ##1 busy ##1 done); // R5

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(bclk_oe)); // R7

  AST_LOCKED_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && cfg_addr == ADDR_CLKCTL && !prot_on) |-> $stable(bclk_oe)); // R8

endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .area     (area),
  .mux_bus  (mux_bus),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .busy     (busy),
  .done     (done),
  .bclk_oe  (bclk_oe),
  .prot_on  (prot_on)
);

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic       clk;
  logic       rst_n;
  logic       req;
  logic [1:0] area;
  logic [1:0] cs_idx;
  logic       mux_bus;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       busy;
  logic       done;
  logic       bclk_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  bus_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .area(area), .cs_idx(cs_idx),
    .mux_bus(mux_bus), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .bclk_oe(bclk_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {req tag[3:0], area[1:0], cs[1:0], mux, wait, speed bits[3:0], len[1:0]}
  localparam logic [15:0] VECS [NVEC] = '{
    {4'd1,  2'd0, 2'd0, 1'b0, 1'b0, 4'hF, 2'd2},  // R1 SFR fast config
    {4'd1,  2'd0, 2'd1, 1'b1, 1'b1, 4'h0, 2'd2},  // R1 SFR slow config
    {4'd2,  2'd1, 2'd0, 1'b0, 1'b0, 4'hF, 2'd1},  // R2
    {4'd2,  2'd1, 2'd2, 1'b0, 1'b0, 4'h0, 2'd1},  // R2 speed bits ignored
    {4'd2,  2'd1, 2'd0, 1'b0, 1'b1, 4'hF, 2'd2},  // R2 wait
    {4'd3,  2'd2, 2'd0, 1'b0, 1'b0, 4'h1, 2'd1},  // R3 cs0 fast
    {4'd3,  2'd2, 2'd0, 1'b0, 1'b0, 4'hE, 2'd2},  // R3 cs0 slow
    {4'd3,  2'd2, 2'd3, 1'b0, 1'b0, 4'h8, 2'd1},  // R3 cs3 fast
    {4'd3,  2'd2, 2'd2, 1'b0, 1'b0, 4'hB, 2'd2},  // R3 cs2 slow
    {4'd4,  2'd2, 2'd1, 1'b0, 1'b1, 4'hF, 2'd2},  // R4 separate
    {4'd4,  2'd2, 2'd1, 1'b1, 1'b1, 4'hF, 2'd3},  // R4 multiplexed
    {4'd5,  2'd2, 2'd2, 1'b1, 1'b0, 4'h0, 2'd3},  // R5
    {4'd5,  2'd2, 2'd2, 1'b1, 1'b0, 4'hF, 2'd3},  // R5 fast bit overruled
    {4'd12, 2'd3, 2'd0, 1'b0, 1'b0, 4'hF, 2'd2}   // R12 reserved code
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp,
                       input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input logic wt, input logic [3:0] bits);
    cfg_write(2'd3, 8'h02);
    cfg_write(2'd1, {wt, 7'b0});
    cfg_write(2'd2, {bits, 4'b0});
    cfg_write(2'd3, 8'h00);
  endtask

  task automatic run_access(input logic [1:0] ar, input logic [1:0] cs, input logic mx,
                            output int len, output bit shape_ok);
    @(negedge clk);
    req = 1'b1; area = ar; cs_idx = cs; mux_bus = mx;
    @(negedge clk);
    req = 1'b0;
    len = 0; shape_ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      len++;
      if (done) begin
        if (busy) shape_ok = 1'b0;
        break;
      end
      if (!busy) shape_ok = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int  len;
    bit  ok;
    rst_n = 1'b0; req = 1'b0; area = 2'd0; cs_idx = 2'd0; mux_bus = 1'b0;
    cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    check(busy == 1'b0, "R6", busy, 0, "busy after reset");
    check(done == 1'b0, "R6", done, 0, "done after reset");
    check(bclk_oe == 1'b1, "R6", bclk_oe, 1, "bclk_oe after reset");
    run_access(2'd1, 2'd0, 1'b0, len, ok);
    check(len == 1, "R6", len, 1, "internal length with reset wait bit");
    run_access(2'd2, 2'd3, 1'b0, len, ok);
    check(len == 2, "R6", len, 2, "external length with reset speed bits");
    // R11 protect reset to 0: locked write must be ignored
    cfg_write(2'd0, 8'h80);
    check(bclk_oe == 1'b1, "R11", bclk_oe, 1, "locked float write after reset");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VECS[i];
      set_cfg(v[6], v[5:2]);
      run_access(v[11:10], v[9:8], v[7], len, ok);
      check(len == int'(v[1:0]), $sformatf("R%0d", v[15:12]), len, v[1:0],
            $sformatf("vector %0d length", i));
      check(ok, "R9", ok, 1, $sformatf("vector %0d busy/done shape", i));
    end

    // R7 / R11: float control under unlock, protect bit persists
    cfg_write(2'd3, 8'h02);
    cfg_write(2'd0, 8'h80);
    check(bclk_oe == 1'b0, "R7", bclk_oe, 0, "float bit set");
    cfg_write(2'd0, 8'h7F);
    check(bclk_oe == 1'b1, "R11", bclk_oe, 1, "second write with protect still set");
    cfg_write(2'd0, 8'h80);
    cfg_write(2'd3, 8'h00);

    // R8 locked writes ignored
    cfg_write(2'd0, 8'h00);
    check(bclk_oe == 1'b0, "R8", bclk_oe, 0, "locked float write");
    set_cfg(1'b0, 4'h0);
    cfg_write(2'd1, 8'h80);
    run_access(2'd1, 2'd0, 1'b0, len, ok);
    check(len == 1, "R8", len, 1, "locked wait write");
    cfg_write(2'd2, 8'hF0);
    run_access(2'd2, 2'd0, 1'b0, len, ok);
    check(len == 2, "R8", len, 2, "locked speed write");

    // R10 back-to-back with req held high
    @(negedge clk);
    req = 1'b1; area = 2'd0; mux_bus = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R10", busy, 1, "first access busy");
    @(negedge clk);
    check(done == 1'b1, "R10", done, 1, "first access done");
    @(negedge clk);
    check(!busy && !done, "R10", {busy, done}, 0, "idle cycle after done");
    @(negedge clk);
    check(busy == 1'b1, "R10", busy, 1, "second access accepted");
    req = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R10", done, 1, "second access done");
    @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule